// File: doc/BRIEF.md
# Fused Dequantize, Normalize and Activate Requantizer

This block is the output stage of a convolution engine. Each cycle it may accept one signed 32-bit accumulator value together with the index of the output channel it belongs to. It returns one signed 8-bit activation for the next layer.

Inside, the integer is first turned into a single-precision float. One float multiply-add follows, and it does two jobs at once: it rescales the integer back to real units and applies batch normalization. The multiplier and offset for this step are stored per channel. Next, a sign gate chooses one of two factors for a final float multiply. A non-negative value is multiplied by the output quantization scale. A negative value is multiplied by the layer slope times that scale, so a slope of zero makes the stage a plain rectifier. Last, the result is rounded and clamped to the symmetric range ±127.

The coefficients are written through a simple parameter port. The per-channel table holds one entry per lane of the 32-wide engine. Subnormal floats are treated as zero, and there is no handling of NaN or infinity.

The block holds no control state machine: it is a straight pipeline of five register stages, named `s1` (converted value and fetched channel coefficients), `s2` (product), `s3` (normalized sum), `s4` (activated value) and `out`.

Top module: `fused_requant`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `out_vld` is 0 and `out_q` is 0.
- R2: A sample accepted on a clock edge with `in_vld` high has its result on `out_vld`/`out_q` five clock edges later. Back-to-back samples produce back-to-back results in the same order.
- R3: For a non-negative normalized value y = acc·M[ch] + B[ch], the output is round(y·Q) clamped to ±127, where M and B are the channel multiplier and offset and Q is the output scale. A tolerance of 1 LSB is allowed for float truncation.
- R4: The positive branch uses only the output scale Q. Changing Q changes the non-negative results to match.
- R5: For a negative y the output is round(y·S·Q), where S is the layer slope.
- R6: With S = 0, every negative y gives exactly 0 (plain rectifier).
- R7: Results saturate to +127 and −127. The code −128 (0x80) is never produced.
- R8: Rounding to integer goes half away from zero: +2.5 gives 3 and −2.5 gives −3.
- R9: `prm_sel` picks the target of a write: 0 = channel multiplier, 1 = channel offset, 2 = output scale Q, 3 = slope S. `prm_idx` picks the channel for codes 0 and 1. A write to one channel leaves every other channel's results unchanged.
- R10: A coefficient whose exponent field is zero (a subnormal, for example 0x00000001) acts as zero. A channel with such a multiplier outputs round(B·Q).
- R11: `out_vld` is low in every cycle that has no accepted sample five edges earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| prm_we | input | 1 | Coefficient write strobe |
| prm_sel | input | 2 | Coefficient target (see R9) |
| prm_idx | input | CH_W | Channel index for per-channel writes |
| prm_data | input | 32 | Coefficient as IEEE single-precision bits |
| in_vld | input | 1 | Accumulator sample valid |
| in_ch | input | CH_W | Channel of the sample |
| in_acc | input | 32 | Signed 32-bit accumulator value |
| out_vld | output | 1 | Result valid |
| out_q | output | 8 | Signed 8-bit activation |

## Verification
Every result is due exactly five rising edges after the edge that captures its sample. The bench drives inputs on falling edges, so a sample placed on the line at one falling edge is read back on the fifth falling edge after it. The streaming test checks the idle, valid and idle pattern at each falling edge in turn.

Coefficient writes are placed on a falling edge and take effect at the next rising edge, always before the sample that depends on them. Results that are exact in float (rounding ties, saturation, subnormals, the rectifier) are compared with zero tolerance. All other results may differ by one LSB from a real-valued model.

// File: rtl/rq_pkg.sv
`timescale 1ns/1ps
package rq_pkg;

    typedef struct packed {
        logic        sgn;
        logic [7:0]  ex;
        logic [22:0] fr;
    } fp32_t;

    typedef enum logic [1:0] {
        SEL_CHMUL  = 2'd0,
        SEL_CHOFF  = 2'd1,
        SEL_QSCALE = 2'd2,
        SEL_SLOPE  = 2'd3
    } prm_sel_e;

    localparam int unsigned FR_W = 23;

    // Round-to-nearest-even on a fraction; bit 23 of the result is the carry
    function automatic logic [FR_W:0] round_fr(input logic [FR_W-1:0] f,
                                               input logic g,
                                               input logic st);
        logic up;
        up = g & (st | f[0]);
        return {1'b0, f} + {{FR_W{1'b0}}, up};
    endfunction

endpackage

// File: rtl/rq_i2f.sv
`timescale 1ns/1ps
module rq_i2f
    import rq_pkg::*;
(
    input  logic signed [31:0] a,
    output fp32_t              y
);
    logic [31:0] mag;
    logic [31:0] sh;
    logic [4:0]  lead;
    logic [23:0] rf;

    always_comb begin
        mag  = a[31] ? 32'(-a) : a;
        lead = '0;
        for (int i = 0; i < 32; i++) begin
            if (mag[i]) lead = 5'(i);
        end
        sh = mag << (5'd31 - lead);
        rf = round_fr(sh[30:8], sh[7], |sh[6:0]);
        y.sgn = a[31];
        y.ex  = 8'(8'd127 + {3'b0, lead} + {7'b0, rf[23]});
        y.fr  = rf[22:0];
        if (!sh[31]) y = '0;
    end
endmodule

// File: rtl/rq_fmul.sv
`timescale 1ns/1ps
module rq_fmul
    import rq_pkg::*;
(
    input  rq_pkg::fp32_t a,
    input  rq_pkg::fp32_t b,
    output rq_pkg::fp32_t y
);
    logic [47:0]       p;
    logic signed [9:0] e;
    logic [22:0]       keep;
    logic              g;
    logic              st;
    logic [23:0]       rf;

    always_comb begin
        p = {1'b1, a.fr} * {1'b1, b.fr};
        e = $signed({2'b0, a.ex}) + $signed({2'b0, b.ex}) - 10'sd127;
        if (p[47]) begin
            keep = p[46:24];
            g    = p[23];
            st   = |p[22:0];
            e    = e + 10'sd1;
        end else begin
            keep = p[45:23];
            g    = p[22];
            st   = |p[21:0];
        end
        rf = round_fr(keep, g, st);
        if (rf[23]) e = e + 10'sd1;
        y.sgn = a.sgn ^ b.sgn;
        y.fr  = rf[22:0];
        y.ex  = e[7:0];
        if (a.ex == 8'd0 || b.ex == 8'd0 || e <= 10'sd0) begin
            y = '0;
        end else if (e >= 10'sd255) begin
            y.ex = 8'hFE;
            y.fr = '1;
        end
    end
endmodule

// File: rtl/rq_fadd.sv
`timescale 1ns/1ps
module rq_fadd
    import rq_pkg::*;
(
    input  rq_pkg::fp32_t a,
    input  rq_pkg::fp32_t b,
    output rq_pkg::fp32_t y
);
    fp32_t             big;
    fp32_t             sml;
    logic [7:0]        d;
    logic [26:0]       mb;
    logic [26:0]       ms;
    logic [27:0]       s;
    logic [26:0]       n;
    logic              xs;
    logic [4:0]        lead;
    logic signed [9:0] e;
    logic [23:0]       rf;

    always_comb begin
        if ({a.ex, a.fr} >= {b.ex, b.fr}) begin
            big = a;
            sml = b;
        end else begin
            big = b;
            sml = a;
        end
        d    = big.ex - sml.ex;
        mb   = {1'b1, big.fr, 3'b000};
        ms   = (sml.ex == 8'd0) ? 27'd0 : ({1'b1, sml.fr, 3'b000} >> d);
        e    = $signed({2'b0, big.ex});
        xs   = 1'b0;
        lead = '0;
        if (big.sgn == sml.sgn) begin
            s = {1'b0, mb} + {1'b0, ms};
            if (s[27]) begin
                n  = s[27:1];
                xs = s[0];
                e  = e + 10'sd1;
            end else begin
                n  = s[26:0];
            end
        end else begin
            s = {1'b0, mb} - {1'b0, ms};
            for (int i = 0; i < 27; i++) begin
                if (s[i]) lead = 5'(i);
            end
            n = s[26:0] << (5'd26 - lead);
            e = e - $signed({5'b0, 5'd26 - lead});
        end
        rf = round_fr(n[25:3], n[2], |n[1:0] | xs);
        if (rf[23]) e = e + 10'sd1;
        y.sgn = big.sgn;
        y.ex  = e[7:0];
        y.fr  = rf[22:0];
        if (big.ex == 8'd0 || n == 27'd0 || e <= 10'sd0) begin
            y = '0;
        end else if (e >= 10'sd255) begin
            y.ex = 8'hFE;
            y.fr = '1;
        end
    end
endmodule

// File: rtl/rq_f2i8.sv
`timescale 1ns/1ps
module rq_f2i8
    import rq_pkg::*;
#(
    parameter int unsigned QMAX = 127
) (
    input  rq_pkg::fp32_t      a,
    output logic signed [7:0]  q
);
    localparam logic [7:0] EX_HALF = 8'd126;
    localparam logic [7:0] EX_SAT  = 8'd134;
    localparam logic [7:0] SH_BASE = 8'd149;

    logic [23:0] t;
    logic [8:0]  r;
    logic [7:0]  mag;

    always_comb begin
        t   = '0;
        r   = '0;
        mag = '0;
        if (a.ex >= EX_SAT) begin
            mag = 8'(QMAX);
        end else if (a.ex >= EX_HALF) begin
            // t = floor(2*|a|); (t+1)/2 rounds half away from zero
            t = {1'b1, a.fr} >> (SH_BASE - a.ex);
            r = ({1'b0, t[7:0]} + 9'd1) >> 1;
            if (t[23:8] != 16'd0 || r > 9'(QMAX)) mag = 8'(QMAX);
            else                                  mag = r[7:0];
        end
        q = a.sgn ? $signed(8'(-mag)) : $signed(mag);
    end
endmodule

// File: rtl/fused_requant.sv
`timescale 1ns/1ps
module fused_requant
    import rq_pkg::*;
#(
    parameter int unsigned N_CH = 32,
    parameter int unsigned QMAX = 127,
    localparam int unsigned CH_W = (N_CH > 1) ? $clog2(N_CH) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                prm_we,
    input  logic [1:0]          prm_sel,
    input  logic [CH_W-1:0]     prm_idx,
    input  logic [31:0]         prm_data,
    input  logic                in_vld,
    input  logic [CH_W-1:0]     in_ch,
    input  logic signed [31:0]  in_acc,
    output logic                out_vld,
    output logic signed [7:0]   out_q
);
    // ---------------- coefficient storage ----------------
    fp32_t ch_mul [N_CH];
    fp32_t ch_off [N_CH];
    fp32_t qscale;
    fp32_t slope;
    fp32_t neg_k;

    for (genvar g = 0; g < N_CH; g++) begin : g_ch
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ch_mul[g] <= '0;
                ch_off[g] <= '0;
            end else if (prm_we && prm_idx == CH_W'(g)) begin
                if (prm_sel == SEL_CHMUL) ch_mul[g] <= prm_data;
                if (prm_sel == SEL_CHOFF) ch_off[g] <= prm_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            qscale <= '0;
            slope  <= '0;
        end else if (prm_we) begin
            if (prm_sel == SEL_QSCALE) qscale <= prm_data;
            if (prm_sel == SEL_SLOPE)  slope  <= prm_data;
        end
    end

    // negative-branch factor is static per layer: slope * output scale
    rq_fmul u_negk (.a(slope), .b(qscale), .y(neg_k));

    // ---------------- pipeline ----------------
    fp32_t x_f, prod_f, sum_f, act_k, act_f;
    logic signed [7:0] q_c;

    logic  s1_vld, s2_vld, s3_vld, s4_vld;
    fp32_t s1_x, s1_mul, s1_off;
    fp32_t s2_prod, s2_off;
    fp32_t s3_sum;
    fp32_t s4_act;

    rq_i2f  u_i2f  (.a(in_acc), .y(x_f));
    rq_fmul u_bnm  (.a(s1_x), .b(s1_mul), .y(prod_f));
    rq_fadd u_bna  (.a(s2_prod), .b(s2_off), .y(sum_f));
    assign act_k = s3_sum.sgn ? neg_k : qscale;
    rq_fmul u_act  (.a(s3_sum), .b(act_k), .y(act_f));
    rq_f2i8 #(.QMAX(QMAX)) u_q (.a(s4_act), .q(q_c));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_vld  <= 1'b0;
            s2_vld  <= 1'b0;
            s3_vld  <= 1'b0;
            s4_vld  <= 1'b0;
            out_vld <= 1'b0;
            s1_x    <= '0;
            s1_mul  <= '0;
            s1_off  <= '0;
            s2_prod <= '0;
            s2_off  <= '0;
            s3_sum  <= '0;
            s4_act  <= '0;
            out_q   <= '0;
        end else begin
            s1_vld  <= in_vld;
            s2_vld  <= s1_vld;
            s3_vld  <= s2_vld;
            s4_vld  <= s3_vld;
            out_vld <= s4_vld;
            s1_x    <= x_f;
            s1_mul  <= ch_mul[in_ch];
            s1_off  <= ch_off[in_ch];
            s2_prod <= prod_f;
            s2_off  <= s1_off;
            s3_sum  <= sum_f;
            s4_act  <= act_f;
            out_q   <= q_c;
        end
    end

    // ---------------- assertions ----------------
    logic [2:0] warm;
    always_ff @(posedge clk) begin
        if (!rst_n)            warm <= '0;
        else if (warm != 3'd5) warm <= warm + 3'd1;
    end

    p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (warm == 3'd5) |-> (out_vld == $past(in_vld, 5)));

    p_never_m128_r7: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld |-> (out_q != 8'sh80));

    p_relu_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (s3_vld && s3_sum.sgn && slope.ex == 8'd0) |=> ##1 (out_q == 8'sd0));

    p_pos_sign_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (s3_vld && !s3_sum.sgn && !qscale.sgn) |=> ##1 (!out_q[7]));

endmodule

// File: tb/fused_requant_bench.sv
`timescale 1ns/1ps
module fused_requant_bench;
    localparam int N_CH = 32;
    localparam int CH_W = 5;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              prm_we = 1'b0;
    logic [1:0]        prm_sel = '0;
    logic [CH_W-1:0]   prm_idx = '0;
    logic [31:0]       prm_data = '0;
    logic              in_vld = 1'b0;
    logic [CH_W-1:0]   in_ch = '0;
    logic signed [31:0] in_acc = '0;
    logic              out_vld;
    logic signed [7:0] out_q;

    int n_run = 0;
    int n_fail = 0;
    real m_mul [N_CH];
    real m_off [N_CH];
    real m_q = 0.0;
    real m_sl = 0.0;

    always #10 clk = ~clk;

    fused_requant #(.N_CH(N_CH)) u_fused_requant (
        .clk(clk), .rst_n(rst_n), .prm_we(prm_we), .prm_sel(prm_sel),
        .prm_idx(prm_idx), .prm_data(prm_data), .in_vld(in_vld),
        .in_ch(in_ch), .in_acc(in_acc), .out_vld(out_vld), .out_q(out_q)
    );

    function automatic logic [31:0] to_bits(real v);
        real a;
        int  e;
        logic [31:0] mbits;
        if (v == 0.0) return 32'd0;
        a = (v < 0.0) ? -v : v;
        e = 0;
        while (a >= 2.0) begin a = a / 2.0; e++; end
        while (a < 1.0)  begin a = a * 2.0; e--; end
        mbits = 32'($rtoi((a - 1.0) * 8388608.0));
        return {(v < 0.0), 8'(e + 127), mbits[22:0]};
    endfunction

    function automatic int model(int acc, real mul, real off);
        real y, z, r;
        y = $itor(acc) * mul + off;
        z = (y >= 0.0) ? y * m_q : y * m_sl * m_q;
        r = (z >= 0.0) ? $floor(z + 0.5) : -$floor(-z + 0.5);
        if (r > 127.0)  r = 127.0;
        if (r < -127.0) r = -127.0;
        return $rtoi(r);
    endfunction

    task automatic chk(string tag, int act, int exp, int tol);
        int d;
        n_run++;
        d = act - exp;
        if (d < 0) d = -d;
        if (d > tol) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wr(logic [1:0] sel, int idx, logic [31:0] bits);
        @(negedge clk);
        prm_we   = 1'b1;
        prm_sel  = sel;
        prm_idx  = CH_W'(idx);
        prm_data = bits;
        @(negedge clk);
        prm_we   = 1'b0;
    endtask

    task automatic set_ch(int ch, real mul, real off);
        m_mul[ch] = mul;
        m_off[ch] = off;
        wr(2'd0, ch, to_bits(mul));
        wr(2'd1, ch, to_bits(off));
    endtask

    task automatic set_layer(real q, real sl);
        m_q  = q;
        m_sl = sl;
        wr(2'd2, 0, to_bits(q));
        wr(2'd3, 0, to_bits(sl));
    endtask

    // one isolated sample; result is read on the fifth falling edge after driving
    task automatic one(string tag, int ch, int acc, int exp, int tol);
        @(negedge clk);
        in_vld = 1'b1;
        in_ch  = CH_W'(ch);
        in_acc = acc;
        @(negedge clk);
        in_vld = 1'b0;
        repeat (3) @(negedge clk);
        chk({tag, " idle before result (R11)"}, int'(out_vld), 0, 0);
        @(negedge clk);
        chk({tag, " valid (R2)"}, int'(out_vld), 1, 0);
        chk(tag, int'(out_q), exp, tol);
        @(negedge clk);
        chk({tag, " valid drops (R11)"}, int'(out_vld), 0, 0);
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 vld in reset", int'(out_vld), 0, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 vld after reset", int'(out_vld), 0, 0);
        chk("R1 q after reset", int'(out_q), 0, 0);
    endtask

    task automatic t_basic;
        set_ch(0, 0.01, 1.5);
        set_layer(1.0, 0.1);
        one("R3 acc 1234", 0, 1234, model(1234, 0.01, 1.5), 1);
        one("R3 acc 0 tie", 0, 0, 2, 0);
        one("R3 acc 777", 0, 777, model(777, 0.01, 1.5), 1);
    endtask

    task automatic t_qscale;
        set_layer(0.5, 0.1);
        one("R4 scale half", 0, 1234, model(1234, 0.01, 1.5), 1);
        set_layer(1.0, 0.1);
    endtask

    task automatic t_negative;
        one("R5 acc -3000", 0, -3000, model(-3000, 0.01, 1.5), 1);
        one("R5 acc -40000", 0, -40000, model(-40000, 0.01, 1.5), 1);
    endtask

    task automatic t_relu;
        set_layer(1.0, 0.0);
        one("R6 relu small", 0, -3000, 0, 0);
        one("R6 relu large", 0, -2000000, 0, 0);
        one("R6 relu positive kept", 0, 1234, model(1234, 0.01, 1.5), 1);
    endtask

    task automatic t_sat;
        set_layer(1.0, 1.0);
        one("R7 sat high", 0, 32'sh7FFFFFFF, 127, 0);
        one("R7 sat low", 0, 32'sh80000000, -127, 0);
        one("R7 sat mid", 0, 50000, 127, 0);
    endtask

    task automatic t_round;
        set_ch(3, 0.5, 0.0);
        one("R8 +2.5", 3, 5, 3, 0);
        one("R8 -2.5", 3, -5, -3, 0);
        one("R8 +1.5", 3, 3, 2, 0);
    endtask

    task automatic t_channels;
        set_ch(5, 2.0, -1.0);
        one("R9 ch5", 5, 20, 39, 0);
        one("R9 ch0 untouched", 0, 1234, model(1234, 0.01, 1.5), 1);
    endtask

    task automatic t_denorm;
        m_mul[7] = 0.0;
        m_off[7] = 3.0;
        wr(2'd0, 7, 32'h0000_0001);
        wr(2'd1, 7, to_bits(3.0));
        one("R10 subnormal mul", 7, 100000, 3, 0);
    endtask

    task automatic t_stream;
        int accs [4] = '{100, -200, 4000, 0};
        int exps [4];
        for (int i = 0; i < 4; i++) exps[i] = model(accs[i], 0.01, 1.5);
        for (int j = 0; j < 10; j++) begin
            @(negedge clk);
            if (j >= 5 && j <= 8) begin
                chk("R2 stream valid", int'(out_vld), 1, 0);
                chk("R2 stream value", int'(out_q), exps[j-5], 1);
            end else begin
                chk("R11 stream idle", int'(out_vld), 0, 0);
            end
            if (j < 4) begin
                in_vld = 1'b1;
                in_ch  = '0;
                in_acc = accs[j];
            end else begin
                in_vld = 1'b0;
            end
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_basic();
        t_qscale();
        t_negative();
        t_relu();
        t_sat();
        t_round();
        t_channels();
        t_denorm();
        set_layer(1.0, 0.1);
        t_stream();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule